// File: doc/BRIEF.md
# Keyed Program-Memory Write Port

This block sits on a processor's data-bus write path and gives software a guarded way to store into program memory, which the processor cannot otherwise write. The low 17 bits of each bus address form the offset. An offset with bit 16 set is an I/O access; any other offset is an ordinary RAM write. The block passes RAM writes through on their own strobe.

Three registers inside the I/O window drive the program-memory write. A key register unlocks the port when it receives one fixed 32-bit value. An address register holds the target program-memory address. A data register fires the write. A data-register write reaches program memory only while the port is unlocked. It uses the bus access size, the held address aligned to that size, byte enables, and data copied into each lane the access covers.

All outputs are registered. Each result appears one clock after the bus write that causes it.

Top module: `pm_keyed_writer`

## Requirements
- R1: After reset both strobes are low, the port is locked and the address register is zero. A data-register write made before any unlock is dropped.
- R2: A write of 0x1337F7D1 to offset 0x1FC80 unlocks the port. A write of any other value to that offset locks it.
- R3: A write to offset 0x1FC84 loads the 32-bit program-memory address register.
- R4: A data-register write (offset 0x1FC88) made while the port is unlocked raises pm_we for exactly one cycle, on the next clock edge. The bus data goes to pm_wdata. Nothing is written to program memory without such a bus write.
- R5: A data-register write made while the port is locked raises neither pm_we nor ram_we.
- R6: Size codes are 0 for byte, 1 for halfword and 2 for word. pm_addr is the held address with bit 0 cleared for a halfword and bits 1:0 cleared for a word. The address register itself is not changed.
- R7: pm_be bit n enables byte lane n (bits 8n+7:8n). A byte access enables the single lane given by address bits 1:0 and repeats the data byte in all four lanes. A halfword access enables lanes 1:0, or lanes 3:2 when address bit 1 is set, and repeats the low halfword in both halves. A word access enables all four lanes.
- R8: A data-register write with size code 3 is dropped.
- R9: A bus write whose offset bit 16 is clear raises ram_we on the next edge. ram_addr carries offset bits 15:0, and ram_size and ram_wdata carry the bus size and data unchanged.
- R10: A write to any other I/O offset raises no strobe and leaves the lock state and the address register unchanged.
- R11: An unlock write takes effect for a data-register write in the very next cycle.
- R12: Address bits above bit 16 play no part in decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Data-bus write strobe |
| bus_addr | input | 32 | Data-bus byte address |
| bus_size | input | 2 | Access size code (0 byte, 1 half, 2 word) |
| bus_wdata | input | 32 | Data-bus write data |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 16 | RAM byte offset |
| ram_size | output | 2 | RAM access size code |
| ram_wdata | output | 32 | RAM write data |
| pm_we | output | 1 | Program-memory write strobe |
| pm_addr | output | 32 | Aligned program-memory byte address |
| pm_size | output | 2 | Program-memory access size code |
| pm_be | output | 4 | Program-memory byte-lane enables |
| pm_wdata | output | 32 | Lane-replicated program-memory data |

## Verification
Every strobe and data output follows the bus write that causes it by exactly one clock edge. The bench therefore drives each stimulus on a falling edge and reads the outputs on the next falling edge. At that point the output register holds the result of that stimulus and of nothing later. Lock and address changes show up one cycle later, through the next data-register write. The bench tests this with a data write placed right after an unlock, and with a data write placed after an unrelated I/O write.

// File: rtl/pm_keyed_writer.sv
module pm_keyed_writer #(
  parameter int          ADDR_W     = 32,
  parameter int          RAM_W      = 16,
  parameter logic [31:0] UNLOCK_KEY = 32'h1337F7D1,
  parameter logic [16:0] KEY_OFS    = 17'h1FC80,
  parameter logic [16:0] ADR_OFS    = 17'h1FC84,
  parameter logic [16:0] DAT_OFS    = 17'h1FC88
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic              ram_we,
  output logic [RAM_W-1:0]  ram_addr,
  output logic [1:0]        ram_size,
  output logic [31:0]       ram_wdata,
  output logic              pm_we,
  output logic [31:0]       pm_addr,
  output logic [1:0]        pm_size,
  output logic [3:0]        pm_be,
  output logic [31:0]       pm_wdata
);

  logic [16:0] ofs;
  logic        is_io, hit_key, hit_adr, hit_dat, fire;
  logic        unlock_q;
  logic [31:0] adr_q, al_addr, lane_data;
  logic [3:0]  lane_be;

  assign ofs     = bus_addr[16:0];
  assign is_io   = ofs[16];
  assign hit_key = bus_we && (ofs == KEY_OFS);
  assign hit_adr = bus_we && (ofs == ADR_OFS);
  assign hit_dat = bus_we && (ofs == DAT_OFS);
  assign fire    = hit_dat && unlock_q && (bus_size != 2'd3);

  always_comb begin
    al_addr   = adr_q;
    lane_be   = 4'b1111;
    lane_data = bus_wdata;
    case (bus_size)
      2'd0: begin
        lane_be   = 4'b0001 << adr_q[1:0];
        lane_data = {4{bus_wdata[7:0]}};
      end
      2'd1: begin
        al_addr   = {adr_q[31:1], 1'b0};
        lane_be   = adr_q[1] ? 4'b1100 : 4'b0011;
        lane_data = {2{bus_wdata[15:0]}};
      end
      default: al_addr = {adr_q[31:2], 2'b00};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlock_q  <= 1'b0;
      adr_q     <= '0;
      pm_we     <= 1'b0;
      pm_addr   <= '0;
      pm_size   <= '0;
      pm_be     <= '0;
      pm_wdata  <= '0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_size  <= '0;
      ram_wdata <= '0;
    end else begin
      if (hit_key) unlock_q <= (bus_wdata == UNLOCK_KEY);
      if (hit_adr) adr_q <= bus_wdata;
      pm_we <= fire;
      if (fire) begin
        pm_addr  <= al_addr;
        pm_size  <= bus_size;
        pm_be    <= lane_be;
        pm_wdata <= lane_data;
      end
      ram_we <= bus_we && !is_io;
      if (bus_we && !is_io) begin
        ram_addr  <= ofs[RAM_W-1:0];
        ram_size  <= bus_size;
        ram_wdata <= bus_wdata;
      end
    end
  end

  // R4
  pm_we_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we |-> $past(bus_we && bus_addr[16:0] == DAT_OFS));

  // R5
  pm_we_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hit_dat && !unlock_q) |-> !pm_we && !ram_we);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pm_we && ram_we));

  // R6
  pm_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we |-> (pm_size == 2'd0) || (pm_size == 2'd1 && !pm_addr[0]) ||
              (pm_size == 2'd2 && pm_addr[1:0] == 2'b00));

  // R7
  pm_be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we |-> $countones(pm_be) == (32'd1 << pm_size));

  // R8
  pm_size3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_we && bus_size == 2'd3) |-> !pm_we);

  // R2
  unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hit_key) |-> unlock_q == ($past(bus_wdata) == UNLOCK_KEY));

endmodule

// File: tb/pm_keyed_writer_tb.sv
module pm_keyed_writer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic        ram_we, pm_we;
  logic [15:0] ram_addr;
  logic [1:0]  ram_size, pm_size;
  logic [31:0] ram_wdata, pm_addr, pm_wdata;
  logic [3:0]  pm_be;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  pm_keyed_writer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_size(ram_size), .ram_wdata(ram_wdata),
    .pm_we(pm_we), .pm_addr(pm_addr), .pm_size(pm_size), .pm_be(pm_be),
    .pm_wdata(pm_wdata));

  // row: we, addr, size, wdata, exp_pm, exp_addr, exp_be, exp_data, exp_ram
  localparam int VW = 137;
  localparam int NV = 18;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 32'h0001FC88, 2'd2, 32'hAAAA5555, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0},        // R1
    {1'b1, 32'h0001FC80, 2'd2, 32'h1337F7D1, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0},        // R2
    {1'b1, 32'h0001FC84, 2'd2, 32'h00000123, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0},        // R3
    {1'b1, 32'h0001FC88, 2'd2, 32'hDEADBEEF, 1'b1, 32'h120, 4'hF, 32'hDEADBEEF, 1'b0},// R4 R6
    {1'b1, 32'h0001FC88, 2'd1, 32'h0000CAFE, 1'b1, 32'h122, 4'hC, 32'hCAFECAFE, 1'b0},// R6 R7
    {1'b1, 32'h0001FC88, 2'd0, 32'h000000A5, 1'b1, 32'h123, 4'h8, 32'hA5A5A5A5, 1'b0},// R7
    {1'b1, 32'h0001FC84, 2'd2, 32'h00000201, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0},        // R3
    {1'b1, 32'h0001FC88, 2'd0, 32'h0000003C, 1'b1, 32'h201, 4'h2, 32'h3C3C3C3C, 1'b0},// R7
    {1'b1, 32'h0001FC88, 2'd1, 32'h00001234, 1'b1, 32'h200, 4'h3, 32'h12341234, 1'b0},// R6
    {1'b1, 32'h0001FC88, 2'd3, 32'h99999999, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0},        // R8
    {1'b1, 32'h0001FFFC, 2'd2, 32'h00000777, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0},        // R10
    {1'b1, 32'h0001FC88, 2'd2, 32'h11223344, 1'b1, 32'h200, 4'hF, 32'h11223344, 1'b0},// R10
    {1'b1, 32'h00024567, 2'd2, 32'h01020304, 1'b0, 32'h4567, 4'h0, 32'h01020304, 1'b1},// R9
    {1'b1, 32'h0001FC80, 2'd2, 32'h1337F7D0, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0},        // R2
    {1'b1, 32'h0001FC88, 2'd2, 32'h0BADF00D, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0},        // R5
    {1'b1, 32'hFF81FC80, 2'd2, 32'h1337F7D1, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0},        // R12
    {1'b1, 32'h0081FC88, 2'd2, 32'h00000055, 1'b1, 32'h200, 4'hF, 32'h00000055, 1'b0},// R11 R12
    {1'b0, 32'h0001FC88, 2'd2, 32'h0, 1'b0, 32'h0, 4'h0, 32'h0, 1'b0}                // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic we, input logic [31:0] a, input logic [1:0] s, input logic [31:0] d);
    bus_we = we; bus_addr = a; bus_size = s; bus_wdata = d;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pm_we reset", {31'b0, pm_we}, 32'd0);
    chk("R1 ram_we reset", {31'b0, ram_we}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      put(v[136], v[135:104], v[103:102], v[101:70]);
      chk($sformatf("row%0d pm_we", i), {31'b0, pm_we}, {31'b0, v[69]});
      chk($sformatf("row%0d ram_we", i), {31'b0, ram_we}, {31'b0, v[0]});
      if (v[69]) begin
        chk($sformatf("row%0d pm_addr", i), pm_addr, v[68:37]);
        chk($sformatf("row%0d pm_be", i), {28'b0, pm_be}, {28'b0, v[36:33]});
        chk($sformatf("row%0d pm_wdata", i), pm_wdata, v[32:1]);
        chk($sformatf("row%0d pm_size", i), {30'b0, pm_size}, {30'b0, v[103:102]});
      end
      if (v[0]) begin
        chk($sformatf("row%0d R9 ram_addr", i), {16'b0, ram_addr}, v[52:37]);
        chk($sformatf("row%0d R9 ram_wdata", i), ram_wdata, v[32:1]);
        chk($sformatf("row%0d R9 ram_size", i), {30'b0, ram_size}, {30'b0, v[103:102]});
      end
    end
    // R1: reset clears unlock and address register
    put(1'b1, 32'h0001FC84, 2'd2, 32'h00000888);
    put(1'b0, 32'h0, 2'd0, 32'h0);
    rst_n = 1'b0;
    put(1'b0, 32'h0, 2'd0, 32'h0);
    chk("R1 pm_we in reset", {31'b0, pm_we}, 32'd0);
    rst_n = 1'b1;
    put(1'b1, 32'h0001FC88, 2'd2, 32'h12345678);
    chk("R1 locked after reset", {31'b0, pm_we}, 32'd0);
    put(1'b1, 32'h0001FC80, 2'd2, 32'h1337F7D1);
    put(1'b1, 32'h0001FC88, 2'd2, 32'h87654321);
    chk("R1 R11 pm_we", {31'b0, pm_we}, 32'd1);
    chk("R1 addr zero after reset", pm_addr, 32'd0);
    // R6: word alignment clears bits 1:0, register keeps them
    put(1'b1, 32'h0001FC84, 2'd2, 32'h00000307);
    put(1'b1, 32'h0001FC88, 2'd2, 32'hCAFEF00D);
    chk("R6 word align", pm_addr, 32'h304);
    put(1'b1, 32'h0001FC88, 2'd0, 32'h000000EE);
    chk("R6 register unchanged", pm_addr, 32'h307);
    chk("R7 byte lane 3", {28'b0, pm_be}, 32'h8);
    // R9: RAM write at offset zero
    put(1'b1, 32'h00000000, 2'd0, 32'h000000FF);
    chk("R9 ram_we", {31'b0, ram_we}, 32'd1);
    chk("R9 pm_we idle", {31'b0, pm_we}, 32'd0);
    put(1'b0, 32'h0, 2'd0, 32'h0);
    chk("R4 R9 idle strobes", {30'b0, pm_we, ram_we}, 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule